// File: doc/BRIEF.md
# Hot-Swap Enumeration and Wake Event Controller

This block raises two host-bus events for a plug-in card. The first is a power-management wake request. It fires only when three things hold together: a downstream device is asking for wake-up, the card's present power state allows wake signalling, and software has enabled wake. Once it fires it stays on until software acknowledges it. The second is a hot-swap enumeration request. It tells the host that the card has just been seated and is ready to be configured, or that the operator has opened the ejector handle on a configured card.

Both event outputs are active-low open-drain lines. Each is modelled as a drive-low enable, and the line floats high whenever that enable is clear. A shared local status pin reads the ejector switch while software leaves the LED off. When software turns the LED on, the pin becomes an output that drives the LED. The ejector input and the wake input are both synchronized and the ejector input is debounced. A single register holds the enables, the sticky status bits and the LED control. The bus reset is asynchronous: it clears the block at once and is released in step with the clock.

Top module: `hsw_wake_ctrl`

## Requirements
- R1: `wake_drv_lo` becomes 1 three rising clock edges after `wake_req_n` falls, provided the wake enable is set and the current power state supports wake throughout. It never turns on unless the synchronized wake request is low and the state supports wake.
- R2: Once on, `wake_drv_lo` stays 1 after `wake_req_n` returns high. It goes to 0 on the edge that leaves either the wake enable or the wake status bit at 0.
- R3: The wake status bit (register bit 1) is set on every edge where the synchronized wake request is low. Writing 1 to it clears it. A set on the same edge wins over the clear.
- R4: The insertion bit (bit 2) is set only by the first closed-switch level accepted after reset. The removal bit (bit 3) is set when an open level is accepted while the configured bit (bit 5) is 1. `enum_drv_lo` is 1 while either event bit is 1.
- R5: Writing 1 to bit 2 or bit 3 clears that event bit. `enum_drv_lo` returns to 0 once both event bits are clear.
- R6: The register layout is as follows. `reg_rdata` bit 0 is the wake enable, bit 1 the wake status, bit 2 insertion, bit 3 removal, bit 4 LED on, bit 5 configured, and bit 6 the debounced switch level (1 = closed, read-only). A write pulse on `reg_wr` loads bits 0, 4 and 5 from `reg_wdata`.
- R7: A low `arst_n` clears every register bit and releases both event outputs at once, without waiting for a clock edge. After `arst_n` rises, the block ignores writes for the first two rising edges.
- R8: While the LED bit is 1, `lstat_oe` and `lstat_out` are 1 and the accepted switch level does not change. While the LED bit is 0, `lstat_oe` is 0.
- R9: `lstat_in` is the switch sense: 1 means the handle is closed. A new switch level is accepted only after the synchronized sense has differed from the accepted level on 16 consecutive edges. With the LED off, a change of `lstat_in` is therefore seen in bit 6 after 18 edges. A shorter pulse has no effect.
- R10: Wake support per power state comes from the parameter `WAKE_MASK`, indexed by `pwr_state`. The default is 4'b1011: states 0, 1 and 3 support wake, and state 2 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low bus reset |
| wake_req_n | input | 1 | Downstream wake request, active low, asynchronous |
| pwr_state | input | 2 | Current power state, 0 to 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 7 | Register read data |
| lstat_in | input | 1 | Local status pin sense (ejector switch, 1 = closed) |
| lstat_oe | output | 1 | Local status pin output enable |
| lstat_out | output | 1 | Local status pin output value (LED drive) |
| wake_drv_lo | output | 1 | Pull the open-drain wake line low |
| enum_drv_lo | output | 1 | Pull the open-drain enumeration line low |

## Verification
Some rules are checked by the assertions on every cycle. The wake line never turns on without a qualified request and never stays on without both its enable and its status bit. An event bit only rises from its own switch transition and only falls from its clear write. The accepted switch level moves only after a full debounce window and never while the LED drives the pin. The bench's scenarios are the only place that shows the exact latencies. They are also the only place that shows a set winning over a clear on the same edge, the masked power state, the once-only insertion event, glitch rejection, and the immediate release on an asynchronous reset followed by ignored writes.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int REG_RW = 6;
  localparam int REG_RD = 7;
  localparam int B_WEN  = 0;
  localparam int B_WSTS = 1;
  localparam int B_INS  = 2;
  localparam int B_REM  = 3;
  localparam int B_LED  = 4;
  localparam int B_CFG  = 5;
  localparam int B_SW   = 6;

  // Wake support lookup: one mask bit per power state.
  function automatic logic wake_supported(input logic [3:0] mask, input logic [1:0] ps);
    return mask[ps];
  endfunction

  // True on the last count of a stability window.
  function automatic logic window_full(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage;
  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) stage <= 2'b00;
    else          stage <= {stage[0], 1'b1};
  end
  assign rst_no = stage[1];
endmodule

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta, hold;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        meta <= 1'b0;
        hold <= 1'b0;
      end else begin
        meta <= d[g];
        hold <= meta;
      end
    end
    assign q[g] = hold;
  end
endmodule

// File: rtl/switch_debounce.sv
module switch_debounce
  import hsw_pkg::*;
#(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic hold,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

  logic [CW-1:0] cnt, cnt_d;
  logic          differs, accept;

  assign differs = !hold && (raw != level);
  assign accept  = differs && window_full(32'(cnt), DEB_LEN);
  assign rise    = accept && raw;
  assign fall    = accept && !raw;

  always_comb begin
    if (!differs || accept) cnt_d = '0;
    else                    cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      level <= 1'b0;
    end else begin
      cnt <= cnt_d;
      if (accept) level <= raw;
    end
  end

  p_no_move_when_driven_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(hold) |-> $stable(level));
  p_full_window_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (level != $past(level)) |-> $past(cnt == CW'(DEB_LEN - 1)));
endmodule

// File: rtl/hsw_wake_ctrl.sv
module hsw_wake_ctrl
  import hsw_pkg::*;
#(
  parameter logic [3:0] WAKE_MASK = 4'b1011,
  parameter int         DEB_LEN   = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wake_req_n,
  input  logic [1:0]        pwr_state,
  input  logic              reg_wr,
  input  logic [REG_RW-1:0] reg_wdata,
  output logic [REG_RD-1:0] reg_rdata,
  input  logic              lstat_in,
  output logic              lstat_oe,
  output logic              lstat_out,
  output logic              wake_drv_lo,
  output logic              enum_drv_lo
);
  logic rst_i;
  logic wake_low, sw_raw;
  logic sw_closed, sw_rise, sw_fall;

  logic en_q, sts_q, ins_q, rem_q, led_q, cfg_q, seen_q, act_q;
  logic en_d, sts_d, ins_d, rem_d, led_d, cfg_d, seen_d, act_d;

  // Named internal events
  logic wake_ok, wake_qual, clr_sts, clr_ins, clr_rem;

  rst_sync u_rst (
    .clk     (clk),
    .arst_ni (arst_n),
    .rst_no  (rst_i)
  );

  sync_2ff #(.WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_ni (rst_i),
    .d      ({~wake_req_n, lstat_in}),
    .q      ({wake_low, sw_raw})
  );

  switch_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk    (clk),
    .rst_ni (rst_i),
    .hold   (led_q),
    .raw    (sw_raw),
    .level  (sw_closed),
    .rise   (sw_rise),
    .fall   (sw_fall)
  );

  assign wake_ok   = wake_supported(WAKE_MASK, pwr_state);
  assign wake_qual = wake_low && wake_ok;
  assign clr_sts   = reg_wr && reg_wdata[B_WSTS];
  assign clr_ins   = reg_wr && reg_wdata[B_INS];
  assign clr_rem   = reg_wr && reg_wdata[B_REM];

  always_comb begin
    en_d   = reg_wr ? reg_wdata[B_WEN] : en_q;
    led_d  = reg_wr ? reg_wdata[B_LED] : led_q;
    cfg_d  = reg_wr ? reg_wdata[B_CFG] : cfg_q;
    sts_d  = wake_low || (sts_q && !clr_sts);
    act_d  = en_d && sts_d && (act_q || wake_qual);
    seen_d = seen_q || sw_rise;
    ins_d  = (sw_rise && !seen_q) || (ins_q && !clr_ins);
    rem_d  = (sw_fall && cfg_q) || (rem_q && !clr_rem);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      sts_q  <= 1'b0;
      ins_q  <= 1'b0;
      rem_q  <= 1'b0;
      led_q  <= 1'b0;
      cfg_q  <= 1'b0;
      seen_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      sts_q  <= sts_d;
      ins_q  <= ins_d;
      rem_q  <= rem_d;
      led_q  <= led_d;
      cfg_q  <= cfg_d;
      seen_q <= seen_d;
      act_q  <= act_d;
    end
  end

  assign wake_drv_lo = act_q;
  assign enum_drv_lo = ins_q || rem_q;
  assign lstat_oe    = led_q;
  assign lstat_out   = led_q;
  assign reg_rdata   = {sw_closed, cfg_q, led_q, rem_q, ins_q, sts_q, en_q};

  p_wake_start_r1: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(act_q) |-> $past(wake_qual));
  p_wake_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_i)
    wake_drv_lo |-> reg_rdata[B_WEN]);
  p_wake_needs_sts_r2: assert property (@(posedge clk) disable iff (!rst_i)
    wake_drv_lo |-> reg_rdata[B_WSTS]);
  p_sts_low_sets_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $past(wake_low) |-> sts_q);
  p_ins_first_only_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ins_q) |-> !$past(seen_q));
  p_rem_needs_cfg_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rem_q) |-> $past(sw_fall && cfg_q));
  p_ins_clear_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(ins_q) |-> $past(clr_ins));
  p_rem_clear_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(rem_q) |-> $past(clr_rem));
endmodule

// File: tb/test_hsw_wake_ctrl.sv
module test_hsw_wake_ctrl;
  localparam int DEB = 16;
  localparam logic [3:0] MASK = 4'b1011;

  logic       clk = 1'b0;
  logic       arst_n = 1'b1;
  logic       wake_req_n = 1'b1;
  logic [1:0] pwr_state = 2'd0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [6:0] reg_rdata;
  logic       lstat_in = 1'b0;
  logic       lstat_oe, lstat_out, wake_drv_lo, enum_drv_lo;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit live = 0;

  always #5 clk = ~clk;

  hsw_wake_ctrl i_hsw_wake_ctrl (
    .clk(clk), .arst_n(arst_n), .wake_req_n(wake_req_n), .pwr_state(pwr_state),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lstat_in(lstat_in), .lstat_oe(lstat_oe), .lstat_out(lstat_out),
    .wake_drv_lo(wake_drv_lo), .enum_drv_lo(enum_drv_lo)
  );

  // Behavioural reference model
  bit m_r1, m_r2, m_w1, m_w2, m_e1, m_e2, m_lvl, m_seen;
  bit m_en, m_sts, m_ins, m_rem, m_led, m_cfg, m_act;
  int m_run;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      {m_r1, m_r2, m_w1, m_w2, m_e1, m_e2, m_lvl, m_seen} = '0;
      {m_en, m_sts, m_ins, m_rem, m_led, m_cfg, m_act} = '0;
      m_run = 0;
    end else if (!m_r2) begin
      m_r2 = m_r1;
      m_r1 = 1'b1;
    end else begin
      bit up, down, ok, n_en, n_sts;
      up = 0; down = 0;
      if (!m_led && (m_e2 != m_lvl)) begin
        if (m_run == DEB - 1) begin
          up = m_e2; down = !m_e2; m_lvl = m_e2; m_run = 0;
        end else m_run++;
      end else m_run = 0;
      ok    = MASK[pwr_state];
      n_en  = reg_wr ? reg_wdata[0] : m_en;
      n_sts = m_w2 || (m_sts && !(reg_wr && reg_wdata[1]));
      m_act = n_en && n_sts && (m_act || (m_w2 && ok));
      m_ins = (up && !m_seen) || (m_ins && !(reg_wr && reg_wdata[2]));
      m_rem = (down && m_cfg) || (m_rem && !(reg_wr && reg_wdata[3]));
      if (up) m_seen = 1'b1;
      m_en = n_en;
      m_sts = n_sts;
      if (reg_wr) begin
        m_led = reg_wdata[4];
        m_cfg = reg_wdata[5];
      end
      m_w2 = m_w1; m_w1 = !wake_req_n;
      m_e2 = m_e1; m_e1 = lstat_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check(wake_drv_lo == m_act, "R1 model wake", wake_drv_lo, m_act);
      check(enum_drv_lo == (m_ins || m_rem), "R4 model enum", enum_drv_lo, m_ins || m_rem);
      check(lstat_oe == m_led && lstat_out == m_led, "R8 model pin", {lstat_oe, lstat_out}, {m_led, m_led});
      check(reg_rdata == {m_lvl, m_cfg, m_led, m_rem, m_ins, m_sts, m_en}, "R6 model reg",
            reg_rdata, {m_lvl, m_cfg, m_led, m_rem, m_ins, m_sts, m_en});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #2 arst_n = 1'b0;
    #1;
    check(reg_rdata == 0 && !wake_drv_lo && !enum_drv_lo && !lstat_oe, "R7 reset state",
          {reg_rdata, wake_drv_lo, enum_drv_lo}, 0);
    cyc(3);
    arst_n = 1'b1;
    live = 1;
    cyc(4);

    // R1 latency and R2 stickiness
    wr(6'b000001);
    wake_req_n = 1'b0;
    cyc(2);
    check(!wake_drv_lo, "R1 not yet after two edges", wake_drv_lo, 0);
    cyc(1);
    check(wake_drv_lo, "R1 on after three edges", wake_drv_lo, 1);
    wake_req_n = 1'b1;
    cyc(6);
    check(wake_drv_lo && reg_rdata[1], "R2 sticky after request ends", {wake_drv_lo, reg_rdata[1]}, 3);
    wr(6'b000011);
    check(!wake_drv_lo && !reg_rdata[1], "R3 status clear releases wake", {wake_drv_lo, reg_rdata[1]}, 0);

    // R3 set wins over clear; R2 enable clear releases
    wake_req_n = 1'b0;
    cyc(5);
    wr(6'b000011);
    check(reg_rdata[1] && wake_drv_lo, "R3 set wins over clear", {wake_drv_lo, reg_rdata[1]}, 3);
    wr(6'b000000);
    check(!wake_drv_lo && reg_rdata[1], "R2 enable clear releases", {wake_drv_lo, reg_rdata[1]}, 1);

    // R10 masked power state
    pwr_state = 2'd2;
    wr(6'b000001);
    cyc(6);
    check(!wake_drv_lo && reg_rdata[1], "R10 state 2 blocks wake", {wake_drv_lo, reg_rdata[1]}, 1);
    pwr_state = 2'd3;
    cyc(1);
    check(wake_drv_lo, "R10 state 3 allows wake", wake_drv_lo, 1);
    wake_req_n = 1'b1;
    cyc(3);
    wr(6'b000011);
    pwr_state = 2'd0;
    check(!wake_drv_lo, "R2 released after acknowledge", wake_drv_lo, 0);

    // R9 debounce latency and R4 insertion
    lstat_in = 1'b1;
    cyc(17);
    check(!enum_drv_lo && !reg_rdata[6], "R9 not accepted at 17 edges", {enum_drv_lo, reg_rdata[6]}, 0);
    cyc(1);
    check(enum_drv_lo && reg_rdata[6] && reg_rdata[2], "R4 insertion at 18 edges",
          {enum_drv_lo, reg_rdata[6], reg_rdata[2]}, 7);
    wr(6'b000100);
    check(!enum_drv_lo && !reg_rdata[2], "R5 insertion clear", {enum_drv_lo, reg_rdata[2]}, 0);

    // R9 glitch rejected
    lstat_in = 1'b0;
    cyc(10);
    lstat_in = 1'b1;
    cyc(30);
    check(reg_rdata[6] && !enum_drv_lo, "R9 short pulse ignored", {reg_rdata[6], enum_drv_lo}, 2);

    // R4 removal while configured, insertion only once
    wr(6'b100000);
    lstat_in = 1'b0;
    cyc(20);
    check(enum_drv_lo && reg_rdata[3] && !reg_rdata[2], "R4 removal event",
          {enum_drv_lo, reg_rdata[3], reg_rdata[2]}, 6);
    lstat_in = 1'b1;
    cyc(20);
    check(reg_rdata[6] && !reg_rdata[2], "R4 second closure no insertion", {reg_rdata[6], reg_rdata[2]}, 2);
    wr(6'b101000);
    check(!enum_drv_lo, "R5 removal clear", enum_drv_lo, 0);

    // R8 LED drives pin, sense frozen
    wr(6'b110000);
    check(lstat_oe && lstat_out, "R8 LED drive", {lstat_oe, lstat_out}, 3);
    lstat_in = 1'b0;
    cyc(30);
    check(reg_rdata[6] && !enum_drv_lo, "R8 sense frozen while driving", {reg_rdata[6], enum_drv_lo}, 2);
    wr(6'b100000);
    check(!lstat_oe, "R8 LED off releases pin", lstat_oe, 0);
    cyc(20);
    check(!reg_rdata[6] && enum_drv_lo, "R9 sense resumes after LED off", {reg_rdata[6], enum_drv_lo}, 1);

    // R7 asynchronous reset mid-operation
    wake_req_n = 1'b0;
    wr(6'b100001);
    cyc(4);
    #2 arst_n = 1'b0;
    #1;
    check(!wake_drv_lo && !enum_drv_lo && reg_rdata == 0, "R7 immediate release",
          {wake_drv_lo, enum_drv_lo, reg_rdata}, 0);
    wake_req_n = 1'b1;
    @(negedge clk);
    arst_n = 1'b1;
    reg_wr = 1'b1; reg_wdata = 6'b110001;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    cyc(2);
    check(reg_rdata == 0 && !lstat_oe, "R7 writes ignored during release", reg_rdata, 0);

    cyc(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule